// File: doc/BRIEF.md
# Packed Vector Lane Shuffle Unit

This block rearranges lanes of two 128-bit vector operands into one 128-bit result. A mode input sets how the operands are read. In word mode each operand holds four 32-bit lanes. In pair mode each operand holds two 64-bit lanes. An 8-bit control byte chooses which source lane feeds each result lane. The block only moves bits and does no arithmetic.

The low half of the result always comes from operand A and the high half always comes from operand B. The control byte chooses only the lane taken from inside each operand. The result is captured in a single register stage. A valid strobe travels alongside the data.

Top module: `lane_shuffle`

## Requirements
- R1: After reset, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` equals the value `inValid` had on the previous clock edge. `result` is updated only on an edge where `inValid` is 1 and keeps its value otherwise.
- R3: Word mode (`pairMode`=0), result lanes 0 and 1: result bits [32k+31:32k] for k=0,1 equal the 32-bit lane of `opA` whose index is `ctrl[2k+1:2k]`. Lane i occupies bits [32i+31:32i].
- R4: Word mode, result lanes 2 and 3: result bits [32k+31:32k] for k=2,3 equal the 32-bit lane of `opB` whose index is `ctrl[2k+1:2k]`.
- R5: Word mode can broadcast. A control value that repeats one index in every field copies a single lane into both result lanes of each half.
- R6: Pair mode (`pairMode`=1): result[63:0] equals `opA` lane `ctrl[0]`, where lane 0 is bits [63:0] and lane 1 is bits [127:64].
- R7: Pair mode: result[127:64] equals `opB` lane `ctrl[1]`.
- R8: Pair mode ignores `ctrl[7:2]`. Two control bytes that differ only in those bits give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and control are valid this cycle |
| pairMode | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| ctrl | input | 8 | Lane select control byte |
| opA | input | 128 | First operand, feeds the low result half |
| opB | input | 128 | Second operand, feeds the high result half |
| outValid | output | 1 | Result is valid |
| result | output | 128 | Shuffled vector |

## Verification
The bench sweeps all 256 control bytes in both modes with random operands. This catches a swapped field order, which would place lanes into the wrong result slots. It also catches a high half drawn from `opA`, which would copy the low source into both halves. In pair mode, control bytes that differ only in the upper six bits must give the same result; a design that decoded pair selects from the wrong bits would give different results. Idle cycles must hold the previous result, so a register that loaded on every edge would be exposed.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
  localparam int VecW   = 128;
  localparam int CtrlW  = 8;
  localparam int WordW  = 32;
  localparam int PairW  = 64;
  localparam int NWord  = VecW / WordW;
  localparam int NPair  = VecW / PairW;
  localparam int WSelW  = $clog2(NWord);

  typedef struct packed {
    logic load;
    logic pairSel;
  } shufStrobe_t;
endpackage

// File: rtl/lane_shuffle_ctrl.sv
module lane_shuffle_ctrl
  import lane_shuffle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        pairMode,
  output shufStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.load    = inValid;
    strobe.pairSel = pairMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/lane_shuffle_dp.sv
module lane_shuffle_dp
  import lane_shuffle_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  shufStrobe_t      strobe,
  input  logic [CtrlW-1:0] ctrl,
  input  logic [VecW-1:0]  opA,
  input  logic [VecW-1:0]  opB,
  output logic [VecW-1:0]  result
);
  logic [VecW-1:0] wordRes;
  logic [VecW-1:0] pairRes;

  genvar k;
  generate
    for (k = 0; k < NWord; k++) begin : g_word
      logic [WSelW-1:0] sel;
      logic [VecW-1:0]  src;
      assign sel = ctrl[WSelW*k +: WSelW];
      assign src = (k < NWord/2) ? opA : opB;
      assign wordRes[WordW*k +: WordW] = src[WordW*sel +: WordW];
    end
    for (k = 0; k < NPair; k++) begin : g_pair
      logic            sel;
      logic [VecW-1:0] src;
      assign sel = ctrl[k];
      assign src = (k == 0) ? opA : opB;
      assign pairRes[PairW*k +: PairW] = src[PairW*sel +: PairW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= strobe.pairSel ? pairRes : wordRes;
  end
endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_shuffle_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             pairMode,
  input  logic [CtrlW-1:0] ctrl,
  input  logic [VecW-1:0]  opA,
  input  logic [VecW-1:0]  opB,
  output logic             outValid,
  output logic [VecW-1:0]  result
);
  shufStrobe_t strobe;

  lane_shuffle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pairMode(pairMode),
    .strobe(strobe), .outValid(outValid)
  );

  lane_shuffle_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrl(ctrl),
    .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: rtl/lane_shuffle_chk.sv
module lane_shuffle_chk
  import lane_shuffle_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             pairMode,
  input logic [CtrlW-1:0] ctrl,
  input logic [VecW-1:0]  opA,
  input logic [VecW-1:0]  opB,
  input logic             outValid,
  input logic [VecW-1:0]  result
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> $stable(result));

  // R6
  pair_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(pairMode)) |->
      result[63:0] == ($past(ctrl[0]) ? $past(opA[127:64]) : $past(opA[63:0])));

  // R7
  pair_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(pairMode)) |->
      result[127:64] == ($past(ctrl[1]) ? $past(opB[127:64]) : $past(opB[63:0])));

  // R3
  word_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(pairMode)) |->
      result[31:0] == $past(opA[32*ctrl[1:0] +: 32]));

  // R4
  word_lane3_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(pairMode)) |->
      result[127:96] == $past(opB[32*ctrl[7:6] +: 32]));
endmodule

bind lane_shuffle lane_shuffle_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .pairMode(pairMode), .ctrl(ctrl),
  .opA(opA), .opB(opB), .outValid(outValid), .result(result)
);

// File: tb/lane_shuffle_bench.sv
module lane_shuffle_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         pairMode = 1'b0;
  logic [7:0]   ctrl = '0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic         outValid;
  logic [127:0] result;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_shuffle u_lane_shuffle (.*);

  function automatic logic [127:0] model(input logic pm, input logic [7:0] c,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    if (pm) begin
      r[63:0]   = c[0] ? a[127:64] : a[63:0];
      r[127:64] = c[1] ? b[127:64] : b[63:0];
    end else begin
      r[31:0]   = a[32*c[1:0] +: 32];
      r[63:32]  = a[32*c[3:2] +: 32];
      r[95:64]  = b[32*c[5:4] +: 32];
      r[127:96] = b[32*c[7:6] +: 32];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation, sample mid-cycle after the capturing edge
  task automatic apply(input logic pm, input logic [7:0] c,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    inValid = 1'b1; pairMode = pm; ctrl = c; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outValid", {127'b0, outValid}, 128'b0);
    check("R1 result", result, 128'b0);
    rstN = 1'b1;
  endtask

  task automatic t_valid_hold();
    logic [127:0] a = rnd128(), b = rnd128(), exp;
    apply(1'b0, 8'h1B, a, b);
    exp = model(1'b0, 8'h1B, a, b);
    check("R2 valid follows", {127'b0, outValid}, 128'd1);
    check("R2 loaded", result, exp);
    opA = rnd128(); opB = rnd128(); ctrl = 8'hE4;
    @(negedge clk);
    check("R2 valid drops", {127'b0, outValid}, 128'b0);
    check("R2 hold when idle", result, exp);
  endtask

  task automatic t_sweep(input logic pm);
    for (int c = 0; c < 256; c++) begin
      logic [127:0] a = rnd128(), b = rnd128();
      apply(pm, c[7:0], a, b);
      if (pm) begin
        check("R6 pair low", {64'b0, result[63:0]}, {64'b0, model(1'b1, c[7:0], a, b)} & {64'b0, {64{1'b1}}});
        check("R7 pair high", {64'b0, result[127:64]}, {64'b0, model(1'b1, c[7:0], a, b) >> 64});
      end else begin
        check("R3 word low", {64'b0, result[63:0]}, {64'b0, model(1'b0, c[7:0], a, b)} & {64'b0, {64{1'b1}}});
        check("R4 word high", {64'b0, result[127:64]}, {64'b0, model(1'b0, c[7:0], a, b) >> 64});
      end
    end
  endtask

  task automatic t_broadcast();
    logic [127:0] a = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    logic [127:0] b = {32'h44440003, 32'h33330002, 32'h22220001, 32'h11110000};
    apply(1'b0, 8'hFF, a, b);
    check("R5 broadcast lane3", result, {32'h44440003, 32'h44440003, 32'hDDDD0003, 32'hDDDD0003});
    apply(1'b0, 8'h55, a, b);
    check("R5 broadcast lane1", result, {32'h22220001, 32'h22220001, 32'hBBBB0001, 32'hBBBB0001});
  endtask

  task automatic t_pair_ignore();
    logic [127:0] a = rnd128(), b = rnd128(), r0;
    apply(1'b1, 8'h02, a, b);
    r0 = result;
    apply(1'b1, 8'hFE, a, b);
    check("R8 upper bits ignored", result, r0);
    apply(1'b1, 8'h56, a, b);
    check("R8 upper bits ignored", result, r0);
    check("R8 expected value", r0, {b[127:64], a[63:0]});
  endtask

  initial begin
    t_reset();
    t_valid_hold();
    t_broadcast();
    t_pair_ignore();
    t_sweep(1'b0);
    t_sweep(1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule